// File: doc/BRIEF.md
# Flash Byte-Program Controller with Completion Polling

This block sequences write operations into a small on-chip flash array modelled behaviourally. A host places an address and a data byte on its inputs, selects an operation with a two-bit mode code, asserts the programming-voltage enable and then raises a program strobe. The controller captures the address, data and operation on the strobe's rising edge. It runs the operation for a fixed number of clock cycles and commits the result to the array when that time has elapsed. While an operation is in progress the ready flag is low.

A byte write can only clear bits: the stored byte becomes the old value ANDed with the data. Restoring ones therefore takes a whole-array erase, which sets every byte to FFh. The host can poll for completion by reading the address it just wrote. Until the write finishes, bit 7 of the read data is the inverse of bit 7 of the data byte being written. Once the write finishes, all eight bits show the stored contents. A strobe edge that arrives during an operation does not start anything and sets a sticky error flag.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) ready is 1, err is 0 and every address reads FFh.
- R2: A rising edge of prog_pulse with mode = 2'b01 (program), vpp_en = 1 and ready = 1 starts a byte write. ready is low for exactly PROG_CYCLES clock cycles, beginning after the edge that samples the strobe.
- R3: A completed byte write leaves the stored byte equal to its previous value AND the latched data byte.
- R4: During a byte write, reading the latched address returns the inverse of the latched data bit 7 on rdata[7] and the old stored bits on rdata[6:0]. Reading any other address returns its stored byte.
- R5: Once ready returns high after a write, all eight rdata bits at that address show the stored value.
- R6: A rising edge of prog_pulse with mode = 2'b10 (erase), vpp_en = 1 and ready = 1 holds ready low for exactly ERASE_CYCLES cycles. After that, every address reads FFh.
- R7: A rising edge of prog_pulse while ready is 0 starts no operation and changes no byte. It sets err, which stays 1 until reset.
- R8: A rising edge of prog_pulse with vpp_en = 0, or with mode 2'b00 or 2'b11, starts nothing, leaves ready at 1, changes no byte and leaves err at 0.
- R9: Changes on addr and wdata after the starting edge do not affect the write in progress.
- R10: Holding prog_pulse high after the starting edge starts only one operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Byte address for program and read |
| wdata | input | 8 | Data byte to program |
| mode | input | 2 | Operation code: 00 read, 01 program, 10 erase, 11 reserved |
| vpp_en | input | 1 | Programming-voltage enable; strobes are ignored while low |
| prog_pulse | input | 1 | Program strobe; its rising edge launches an operation |
| rdata | output | 8 | Read data, with bit 7 inverted as a poll at the address being written |
| ready | output | 1 | High when no operation is running |
| err | output | 1 | Sticky flag: a strobe arrived while busy |

## Verification
The assertions assume that rst_n is low at the first clock edge, and that PROG_CYCLES and ERASE_CYCLES are at least one. The assertions on array contents assume that the write and erase commands come only from the internal timer, so the two are never active together. The bench drives every input on the falling clock edge and holds each strobe for at least one full cycle, so every strobe edge is seen by exactly one rising clock edge. The bench keeps its own copy of the array, updated by the AND rule and by erase, and compares the read data against that copy after the combinational read path has settled.

// File: rtl/flash_prog_pkg.sv
// Package: operation codes and constants shared by the flash program controller.
// Assumes: the mode input is decoded directly into flash_op_e.
package flash_prog_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_PROG  = 2'b01,
        OP_ERASE = 2'b10,
        OP_RSVD  = 2'b11
    } flash_op_e;

    localparam logic [7:0] BLANK_BYTE = 8'hFF;
endpackage

// File: rtl/flash_op_timer.sv
// Module: flash_op_timer
// Counts down the self-timed duration of one operation. done is high in the
// last busy cycle, so the commit and the drop of busy share one clock edge.
// Assumes: start only when idle; load_val = duration - 1.
module flash_op_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    // Purpose: load the count on start, decrement while busy, release at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= load_val;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    // Purpose: flag the final cycle of the operation.
    always_comb done = busy && (cnt == '0);

    p_start_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    p_done_releases_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> !busy);
    p_counting_stays_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy);
endmodule

// File: rtl/flash_cell_array.sv
// Module: flash_cell_array
// Behavioural byte array. A write ANDs data into the cell; erase sets all cells
// to FFh. Reset models the shipped erased state. Combinational read port.
// Assumes: wr_en and erase_all are never high together.
module flash_cell_array
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              erase_all,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    // Purpose: apply erase or a bit-clearing write to the cells.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n || erase_all)
                mem[i] <= BLANK_BYTE;
            else if (wr_en && (wr_addr == ADDR_W'(i)))
                mem[i] <= mem[i] & wr_data;
        end
    end

    // Purpose: asynchronous read of the addressed cell.
    always_comb rd_data = mem[rd_addr];

    p_write_only_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !erase_all |=> mem[$past(wr_addr)] == ($past(mem[wr_addr]) & $past(wr_data)));
    p_erase_blanks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_all |=> (mem[0] == BLANK_BYTE) && (mem[DEPTH-1] == BLANK_BYTE));
    p_no_dual_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && erase_all));
endmodule

// File: rtl/flash_prog_ctrl.sv
// Module: flash_prog_ctrl (top)
// Detects the program strobe edge, launches program/erase operations, latches
// their operands, drives the polling read mux and keeps the sticky error flag.
// Assumes: synchronous inputs; PROG_CYCLES and ERASE_CYCLES >= 1.
module flash_prog_ctrl
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W       = 6,
    parameter int PROG_CYCLES  = 20,
    parameter int ERASE_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [1:0]        mode,
    input  logic              vpp_en,
    input  logic              prog_pulse,
    output logic [7:0]        rdata,
    output logic              ready,
    output logic              err
);
    localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    logic              pulse_q, pulse_rise, launch, busy, done;
    logic              op_ok;
    flash_op_e         req_op, lat_op;
    logic [ADDR_W-1:0] lat_addr;
    logic [7:0]        lat_data, arr_rd;
    logic [CNT_W-1:0]  load_val;
    logic              wr_en, erase_all, polling;

    // Purpose: remember the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= prog_pulse;
    end

    // Purpose: decode the request and decide whether it may launch.
    always_comb begin
        req_op     = flash_op_e'(mode);
        pulse_rise = prog_pulse && !pulse_q;
        op_ok      = (req_op == OP_PROG) || (req_op == OP_ERASE);
        launch     = pulse_rise && vpp_en && op_ok && !busy;
        load_val   = (req_op == OP_ERASE) ? CNT_W'(ERASE_CYCLES - 1)
                                          : CNT_W'(PROG_CYCLES - 1);
    end

    // Purpose: capture the operands of an accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_op   <= OP_READ;
            lat_addr <= '0;
            lat_data <= BLANK_BYTE;
        end else if (launch) begin
            lat_op   <= req_op;
            lat_addr <= addr;
            lat_data <= wdata;
        end
    end

    // Purpose: sticky flag for a strobe edge arriving during an operation.
    always_ff @(posedge clk) begin
        if (!rst_n)                err <= 1'b0;
        else if (pulse_rise && busy) err <= 1'b1;
    end

    flash_op_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(launch), .load_val(load_val),
        .busy(busy), .done(done)
    );

    // Purpose: turn completion into the matching array command.
    always_comb begin
        wr_en     = done && (lat_op == OP_PROG);
        erase_all = done && (lat_op == OP_ERASE);
    end

    flash_cell_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(lat_addr),
        .wr_data(lat_data), .erase_all(erase_all), .rd_addr(addr), .rd_data(arr_rd)
    );

    // Purpose: read mux with inverted bit 7 while the addressed byte is being written.
    always_comb begin
        polling = busy && (lat_op == OP_PROG) && (addr == lat_addr);
        rdata   = polling ? {~lat_data[7], arr_rd[6:0]} : arr_rd;
        ready   = !busy;
    end

    p_busy_pulse_sets_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_rise && !ready |=> err);
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    p_operands_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> $stable(lat_addr) && $stable(lat_data) && $stable(lat_op));
    p_blocked_request_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready && pulse_rise && (!vpp_en || !op_ok) |=> ready);
    p_accept_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready && pulse_rise && vpp_en && op_ok |=> !ready);
    p_level_single_shot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prog_pulse && $past(prog_pulse) && ready |=> ready);
endmodule

// File: tb/flash_prog_ctrl_bench.sv
`timescale 1ns/1ps
module flash_prog_ctrl_bench;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;
    localparam int PC = 20;
    localparam int EC = 40;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [1:0] mode = 2'b00;
    logic vpp_en = 1'b0, prog_pulse = 1'b0;
    logic [7:0] rdata;
    logic ready, err;

    int n_checks = 0, n_fails = 0;
    bit finished = 0;
    logic [7:0] model [DEPTH];

    always #2.5 clk = ~clk;

    flash_prog_ctrl #(.ADDR_W(AW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) u_flash_prog_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .mode(mode),
        .vpp_en(vpp_en), .prog_pulse(prog_pulse), .rdata(rdata), .ready(ready), .err(err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic read_at(input logic [AW-1:0] a, output logic [7:0] v);
        addr = a; #1; v = rdata;
    endtask

    // Compare every address against the model; one check per sweep.
    task automatic sweep(input string req);
        int bad = 0; int first = -1;
        logic [7:0] v;
        for (int i = 0; i < DEPTH; i++) begin
            read_at(AW'(i), v);
            if (v !== model[i]) begin bad++; if (first < 0) first = i; end
        end
        if (bad != 0) begin
            read_at(AW'(first), v);
            chk(0, req, v, model[first]);
        end else chk(1, req, 0, 0);
    endtask

    task automatic strobe(input logic [1:0] m, input logic [AW-1:0] a,
                          input logic [7:0] d, input logic v);
        @(negedge clk);
        addr = a; wdata = d; mode = m; vpp_en = v; prog_pulse = 1'b1;
        @(negedge clk);
        prog_pulse = 1'b0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (!ready) begin n++; @(negedge clk); end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        #1;
        chk(ready === 1'b1, "R1 ready", ready, 1);
        chk(err === 1'b0, "R1 err", err, 0);
        sweep("R1 blank array");
    endtask

    task automatic t_program(input logic [AW-1:0] a, input logic [7:0] d);
        int n; logic [7:0] v; logic [7:0] old;
        old = model[a];
        strobe(2'b01, a, d, 1'b1);
        read_at(a, v);
        chk(v === {~d[7], old[6:0]}, "R4 poll value", v, {~d[7], old[6:0]});
        read_at(a ^ AW'(1), v);
        chk(v === model[a ^ AW'(1)], "R4 other address", v, model[a ^ AW'(1)]);
        busy_len(n);
        chk(n == PC, "R2 busy length", n, PC);
        model[a] = old & d;
        read_at(a, v);
        chk(v === model[a], "R3 R5 stored value", v, model[a]);
    endtask

    task automatic t_erase;
        int n;
        strobe(2'b10, 0, 8'h00, 1'b1);
        busy_len(n);
        chk(n == EC, "R6 erase length", n, EC);
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        sweep("R6 erased array");
    endtask

    task automatic t_ignored;
        logic [1:0] modes [3] = '{2'b01, 2'b00, 2'b11};
        logic vs [3] = '{1'b0, 1'b1, 1'b1};
        logic [7:0] v;
        for (int k = 0; k < 3; k++) begin
            strobe(modes[k], 6'd9, 8'h00, vs[k]);
            #1;
            chk(ready === 1'b1, "R8 ready stays", ready, 1);
            chk(err === 1'b0, "R8 no err", err, 0);
            read_at(6'd9, v);
            chk(v === model[9], "R8 byte unchanged", v, model[9]);
        end
    endtask

    task automatic t_latch;
        int n; logic [7:0] v;
        strobe(2'b01, 6'd20, 8'hA5, 1'b1);
        addr = 6'd21; wdata = 8'h00;
        busy_len(n);
        model[20] = model[20] & 8'hA5;
        read_at(6'd20, v);
        chk(v === model[20], "R9 latched target", v, model[20]);
        read_at(6'd21, v);
        chk(v === model[21], "R9 other untouched", v, model[21]);
    endtask

    task automatic t_level;
        int n; logic [7:0] v;
        @(negedge clk);
        addr = 6'd30; wdata = 8'hF0; mode = 2'b01; vpp_en = 1'b1; prog_pulse = 1'b1;
        @(negedge clk);
        addr = 6'd31; wdata = 8'h0F;
        busy_len(n);
        repeat (3) @(negedge clk);
        chk(ready === 1'b1, "R10 no relaunch", ready, 1);
        prog_pulse = 1'b0;
        model[30] = model[30] & 8'hF0;
        read_at(6'd31, v);
        chk(v === model[31], "R10 single write", v, model[31]);
        read_at(6'd30, v);
        chk(v === model[30], "R10 first write done", v, model[30]);
    endtask

    task automatic t_busy_pulse;
        int n; logic [7:0] v;
        strobe(2'b01, 6'd40, 8'h3C, 1'b1);
        @(negedge clk);
        addr = 6'd41; wdata = 8'h00; prog_pulse = 1'b1;
        @(negedge clk);
        prog_pulse = 1'b0;
        chk(err === 1'b1, "R7 err set", err, 1);
        busy_len(n);
        model[40] = model[40] & 8'h3C;
        read_at(6'd41, v);
        chk(v === model[41], "R7 second strobe ignored", v, model[41]);
        t_program(6'd42, 8'h77);
        chk(err === 1'b1, "R7 err sticky", err, 1);
    endtask

    initial begin
        t_reset();
        t_program(6'd5, 8'h5A);
        t_program(6'd5, 8'hF3);
        t_program(6'd63, 8'h7E);
        t_program(6'd0, 8'h80);
        t_ignored();
        t_latch();
        t_level();
        t_erase();
        t_program(6'd5, 8'hC3);
        t_busy_pulse();
        t_reset();
        chk(err === 1'b0, "R1 R7 err cleared by reset", err, 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule